// File: doc/BRIEF.md
# 32-Pin Event-Detecting GPIO Bank

This block is one bank of 32 general-purpose pins behind a 32-bit register bus. Software chooses, pin by pin, whether the pin is an input or drives a stored output value. Input pins pass through a two-flop synchronizer and are then watched for rising edges, falling edges, a high level or a low level, each enabled per pin. Any qualified event sets the pin's bit in two independent event-flag words. Each flag word has its own enable word and its own interrupt line, so two consumers can take interrupts from the same bank without sharing masks.

Besides plain read/write registers, the bank offers write-one-to-set and write-one-to-clear alias addresses for both enable words, the wakeup enable word and the output data. These let software change single bits without a read-modify-write. Byte and halfword writes are merged into the addressed lanes. A configuration register carries a soft-reset trigger, a wakeup gate and a two-bit idle-mode field, and a sticky wakeup request output is raised when an enabled pin sees an event while the gate is open. Two debounce words are kept for software but do not filter anything.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, the direction word reads 0xFFFFFFFF (all pins inputs, `pin_drive_en` = 0), the control word reads 2, the identity word at 0x00 reads the parameter `REV_ID`, the health word at 0x14 reads 1, and all other registers, both interrupt lines and `wake_req` read 0.
- R2: A direction bit of 1 makes the pin an input; `pin_drive_en` is the bitwise inverse of the direction word (0x34) and `pin_out` is the output data word (0x3C).
- R3: The data-in word (0x38) reads the synchronized pins. On an input pin, a 0-to-1 change with its bit set in the rise word (0x48), or a 1-to-0 change with its bit set in the fall word (0x4C), sets that pin's bit in both flag words (A at 0x18, B at 0x28); changes on output pins set nothing.
- R4: While an input pin is high with its bit set in the high-level word (0x44), or low with its bit set in the low-level word (0x40), its bit in both flag words is set every cycle, so clearing it does not make it read 0, and a level word write takes effect without any pin change.
- R5: Writing ones to a flag word clears those bits; an event in the same cycle wins over the clear.
- R6: `irq_a` is high exactly when some bit is set in both flag word A and enable word A (0x1C); `irq_b` uses flag word B and enable word B (0x2C) independently.
- R7: Alias addresses: 0x60/0x64 clear/set bits of enable A, 0x70/0x74 of enable B, 0x80/0x84 of the wakeup enable (0x20), 0x90/0x94 of output data. Reading an alias returns its base register.
- R8: `bus_size` encodes 0 byte, 1 halfword, 2 or 3 word; a sub-word write takes its data from the low bits of `bus_wdata` and places it at lane `bus_addr[1:0]`. Ordinary registers keep their other lanes; flag and alias registers see zeros in the other lanes. A sub-word read returns the word shifted right by 8 times `bus_addr[1:0]`.
- R9: `wake_req` is set when configuration bit 2 is 1, configuration bits 4:3 are not 0, and an event occurs on a pin whose wakeup enable bit is 1; once set it stays set until reset or soft reset.
- R10: The configuration word (0x10) stores the written value ANDed with 0x1D, including idle-mode value 3. Writing it with bit 1 set returns every other register and `wake_req` to the R1 values.
- R11: Writes to 0x00, 0x14 and 0x38 change nothing. The control word (0x30) keeps 3 bits, the debounce-enable word (0x50) keeps 32 bits and the debounce-time word (0x54) keeps 8 bits; these are only stored.
- R12: Reads of addresses that decode to no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data, right-aligned for sub-word writes |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data word |
| pin_drive_en | output | 32 | 1 where the pin drives `pin_out` |
| irq_a | output | 1 | Interrupt from flag word A |
| irq_b | output | 1 | Interrupt from flag word B |
| wake_req | output | 1 | Sticky wakeup request |

## Verification
The assertions take for granted that a bus write is held for a single cycle, that at most one register is addressed per cycle, and that `pin_in` changes slowly enough for the two-flop synchronizer to see every level for at least one cycle. The bench drives each access for exactly one clock between falling edges, moves pins only on falling edges and then waits several cycles before reading flags, so each pin level is held far longer than the synchronizer needs. Events are provoked one scenario at a time, with detection words cleared between scenarios, so a level enable never masks an edge check.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  // word addresses; software decodes these, so they are fixed
  localparam logic [7:0] A_IDENT    = 8'h00;
  localparam logic [7:0] A_CFG      = 8'h10;
  localparam logic [7:0] A_HEALTH   = 8'h14;
  localparam logic [7:0] A_FLAG_A   = 8'h18;
  localparam logic [7:0] A_ENA_A    = 8'h1C;
  localparam logic [7:0] A_WAKE_EN  = 8'h20;
  localparam logic [7:0] A_FLAG_B   = 8'h28;
  localparam logic [7:0] A_ENA_B    = 8'h2C;
  localparam logic [7:0] A_CTRL     = 8'h30;
  localparam logic [7:0] A_DIR      = 8'h34;
  localparam logic [7:0] A_DIN      = 8'h38;
  localparam logic [7:0] A_DOUT     = 8'h3C;
  localparam logic [7:0] A_LVL_LO   = 8'h40;
  localparam logic [7:0] A_LVL_HI   = 8'h44;
  localparam logic [7:0] A_RISE     = 8'h48;
  localparam logic [7:0] A_FALL     = 8'h4C;
  localparam logic [7:0] A_DBC_EN   = 8'h50;
  localparam logic [7:0] A_DBC_T    = 8'h54;
  localparam logic [7:0] A_ENA_A_C  = 8'h60;
  localparam logic [7:0] A_ENA_A_S  = 8'h64;
  localparam logic [7:0] A_ENA_B_C  = 8'h70;
  localparam logic [7:0] A_ENA_B_S  = 8'h74;
  localparam logic [7:0] A_WAKE_C   = 8'h80;
  localparam logic [7:0] A_WAKE_S   = 8'h84;
  localparam logic [7:0] A_DOUT_C   = 8'h90;
  localparam logic [7:0] A_DOUT_S   = 8'h94;

  localparam logic [7:0] CFG_KEEP    = 8'h1D;
  localparam int         CFG_SRST    = 1;
  localparam int         CFG_WAKE_ON = 2;
  localparam int         CFG_IDLE_LO = 3;
  localparam int         CFG_IDLE_HI = 4;

  // bit shift that moves a right-aligned sub-word to its lane
  function automatic logic [4:0] lane_shift(input logic [1:0] size, input logic [1:0] off);
    if (size == SZ_BYTE || size == SZ_HALF) return {off, 3'b000};
    return 5'd0;
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
    case (size)
      SZ_BYTE: return 32'h0000_00FF << lane_shift(size, off);
      SZ_HALF: return 32'h0000_FFFF << lane_shift(size, off);
      default: return '1;
    endcase
  endfunction

  // data placed in its lane, other lanes zero
  function automatic logic [DW-1:0] lane_place(input logic [1:0] size, input logic [1:0] off,
                                               input logic [DW-1:0] wdata);
    return (wdata << lane_shift(size, off)) & lane_mask(size, off);
  endfunction

  // data placed in its lane, other lanes kept from cur
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] cur, input logic [1:0] size,
                                               input logic [1:0] off, input logic [DW-1:0] wdata);
    return (cur & ~lane_mask(size, off)) | lane_place(size, off, wdata);
  endfunction

  function automatic logic [DW-1:0] level_hit(input logic [DW-1:0] din, input logic [DW-1:0] lo,
                                              input logic [DW-1:0] hi);
    return (din & hi) | (~din & lo);
  endfunction

  function automatic logic [DW-1:0] edge_hit(input logic [DW-1:0] din, input logic [DW-1:0] prev,
                                             input logic [DW-1:0] rise, input logic [DW-1:0] fall);
    return (din & ~prev & rise) | (~din & prev & fall);
  endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] dir_in,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] lvl_lo,
  input  logic [W-1:0] lvl_hi,
  output logic [W-1:0] ev
);
  logic [W-1:0] prev_q;
  logic [W-1:0] edge_ev;
  logic [W-1:0] lvl_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  assign edge_ev = edge_hit(din, prev_q, rise_en, fall_en);
  assign lvl_ev  = level_hit(din, lvl_lo, lvl_hi);
  assign ev      = dir_in & (edge_ev | lvl_ev);
endmodule

// File: rtl/gpio_evt_lanes.sv
module gpio_evt_lanes
  import gpio_evt_pkg::*;
(
  input  logic [1:0]    size,
  input  logic [1:0]    off,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cur,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] placed
);
  assign merged = lane_merge(cur, size, off, wdata);
  assign placed = lane_place(size, off, wdata);
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REV_ID      = 8'h30,
  parameter int         CTRL_W      = 3,
  parameter int         CTRL_RST    = 2,
  parameter int         DBT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_drive_en,
  output logic              irq_a,
  output logic              irq_b,
  output logic              wake_req
);
  localparam logic [CTRL_W-1:0] CTRL_INIT = CTRL_W'(CTRL_RST);

  logic [7:0]        cfg_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     dir_q, dout_q, ena_a_q, ena_b_q, wake_en_q;
  logic [DW-1:0]     lvl_lo_q, lvl_hi_q, rise_q, fall_q, dbc_en_q;
  logic [DBT_W-1:0]  dbc_t_q;
  logic [DW-1:0]     flag_a_q, flag_b_q;
  logic              wake_q;

  logic [DW-1:0]     din_sync;
  logic [DW-1:0]     ev_bits;
  logic [ADDR_W-1:0] word_addr;
  logic [DW-1:0]     cur_word;
  logic [DW-1:0]     wr_merged, wr_placed;
  logic              wr_go;
  logic              soft_rst_hit;
  logic              wake_ok;
  logic              wake_hit;
  logic [DW-1:0]     clr_a, clr_b;

  gpio_evt_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (pin_in), .q (din_sync)
  );

  gpio_evt_detect #(.W(DW)) u_detect (
    .clk (clk), .rst_n (rst_n), .din (din_sync), .dir_in (dir_q),
    .rise_en (rise_q), .fall_en (fall_q), .lvl_lo (lvl_lo_q), .lvl_hi (lvl_hi_q),
    .ev (ev_bits)
  );

  assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};

  // read mux; alias addresses return their base register
  always_comb begin
    cur_word = '0;
    case (word_addr)
      ADDR_W'(A_IDENT):                                  cur_word = DW'(REV_ID);
      ADDR_W'(A_CFG):                                    cur_word = DW'(cfg_q);
      ADDR_W'(A_HEALTH):                                 cur_word = DW'(1);
      ADDR_W'(A_FLAG_A):                                 cur_word = flag_a_q;
      ADDR_W'(A_FLAG_B):                                 cur_word = flag_b_q;
      ADDR_W'(A_ENA_A), ADDR_W'(A_ENA_A_C), ADDR_W'(A_ENA_A_S): cur_word = ena_a_q;
      ADDR_W'(A_ENA_B), ADDR_W'(A_ENA_B_C), ADDR_W'(A_ENA_B_S): cur_word = ena_b_q;
      ADDR_W'(A_WAKE_EN), ADDR_W'(A_WAKE_C), ADDR_W'(A_WAKE_S): cur_word = wake_en_q;
      ADDR_W'(A_CTRL):                                   cur_word = DW'(ctrl_q);
      ADDR_W'(A_DIR):                                    cur_word = dir_q;
      ADDR_W'(A_DIN):                                    cur_word = din_sync;
      ADDR_W'(A_DOUT), ADDR_W'(A_DOUT_C), ADDR_W'(A_DOUT_S):    cur_word = dout_q;
      ADDR_W'(A_LVL_LO):                                 cur_word = lvl_lo_q;
      ADDR_W'(A_LVL_HI):                                 cur_word = lvl_hi_q;
      ADDR_W'(A_RISE):                                   cur_word = rise_q;
      ADDR_W'(A_FALL):                                   cur_word = fall_q;
      ADDR_W'(A_DBC_EN):                                 cur_word = dbc_en_q;
      ADDR_W'(A_DBC_T):                                  cur_word = DW'(dbc_t_q);
      default:                                           cur_word = '0;
    endcase
  end

  assign bus_rdata = cur_word >> lane_shift(bus_size, bus_addr[1:0]);

  gpio_evt_lanes u_lanes (
    .size (bus_size), .off (bus_addr[1:0]), .wdata (bus_wdata), .cur (cur_word),
    .merged (wr_merged), .placed (wr_placed)
  );

  assign wr_go        = bus_sel && bus_wr;
  assign soft_rst_hit = wr_go && (word_addr == ADDR_W'(A_CFG)) && wr_merged[CFG_SRST];
  assign wake_ok      = cfg_q[CFG_WAKE_ON] && (cfg_q[CFG_IDLE_HI:CFG_IDLE_LO] != 2'b00);
  assign wake_hit     = wake_ok && ((ev_bits & wake_en_q) != '0);
  assign clr_a        = (wr_go && word_addr == ADDR_W'(A_FLAG_A)) ? wr_placed : '0;
  assign clr_b        = (wr_go && word_addr == ADDR_W'(A_FLAG_B)) ? wr_placed : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      ctrl_q    <= CTRL_INIT;
      dir_q     <= '1;
      dout_q    <= '0;
      ena_a_q   <= '0;
      ena_b_q   <= '0;
      wake_en_q <= '0;
      lvl_lo_q  <= '0;
      lvl_hi_q  <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      dbc_en_q  <= '0;
      dbc_t_q   <= '0;
      flag_a_q  <= '0;
      flag_b_q  <= '0;
      wake_q    <= 1'b0;
    end else if (soft_rst_hit) begin
      cfg_q     <= wr_merged[7:0] & CFG_KEEP;
      ctrl_q    <= CTRL_INIT;
      dir_q     <= '1;
      dout_q    <= '0;
      ena_a_q   <= '0;
      ena_b_q   <= '0;
      wake_en_q <= '0;
      lvl_lo_q  <= '0;
      lvl_hi_q  <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      dbc_en_q  <= '0;
      dbc_t_q   <= '0;
      flag_a_q  <= '0;
      flag_b_q  <= '0;
      wake_q    <= 1'b0;
    end else begin
      // events win over a same-cycle clear
      flag_a_q <= (flag_a_q & ~clr_a) | ev_bits;
      flag_b_q <= (flag_b_q & ~clr_b) | ev_bits;
      wake_q   <= wake_q | wake_hit;
      if (wr_go) begin
        case (word_addr)
          ADDR_W'(A_CFG):     cfg_q     <= wr_merged[7:0] & CFG_KEEP;
          ADDR_W'(A_ENA_A):   ena_a_q   <= wr_merged;
          ADDR_W'(A_ENA_A_C): ena_a_q   <= ena_a_q & ~wr_placed;
          ADDR_W'(A_ENA_A_S): ena_a_q   <= ena_a_q | wr_placed;
          ADDR_W'(A_ENA_B):   ena_b_q   <= wr_merged;
          ADDR_W'(A_ENA_B_C): ena_b_q   <= ena_b_q & ~wr_placed;
          ADDR_W'(A_ENA_B_S): ena_b_q   <= ena_b_q | wr_placed;
          ADDR_W'(A_WAKE_EN): wake_en_q <= wr_merged;
          ADDR_W'(A_WAKE_C):  wake_en_q <= wake_en_q & ~wr_placed;
          ADDR_W'(A_WAKE_S):  wake_en_q <= wake_en_q | wr_placed;
          ADDR_W'(A_CTRL):    ctrl_q    <= wr_merged[CTRL_W-1:0];
          ADDR_W'(A_DIR):     dir_q     <= wr_merged;
          ADDR_W'(A_DOUT):    dout_q    <= wr_merged;
          ADDR_W'(A_DOUT_C):  dout_q    <= dout_q & ~wr_placed;
          ADDR_W'(A_DOUT_S):  dout_q    <= dout_q | wr_placed;
          ADDR_W'(A_LVL_LO):  lvl_lo_q  <= wr_merged;
          ADDR_W'(A_LVL_HI):  lvl_hi_q  <= wr_merged;
          ADDR_W'(A_RISE):    rise_q    <= wr_merged;
          ADDR_W'(A_FALL):    fall_q    <= wr_merged;
          ADDR_W'(A_DBC_EN):  dbc_en_q  <= wr_merged;
          ADDR_W'(A_DBC_T):   dbc_t_q   <= wr_merged[DBT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_a        = |(flag_a_q & ena_a_q);
  assign irq_b        = |(flag_b_q & ena_b_q);
  assign wake_req     = wake_q;
  assign pin_out      = dout_q;
  assign pin_drive_en = ~dir_q;
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_a,
  input logic              wake_req,
  input logic [31:0]       ev_bits,
  input logic [31:0]       dir_q,
  input logic [31:0]       flag_a_q,
  input logic [31:0]       flag_b_q,
  input logic              wake_ok,
  input logic [31:0]       wake_en_q,
  input logic              soft_rst_hit
);
  // R3: detection never reports a driven pin
  a_r3_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bits & ~dir_q) == 32'h0);

  // R5: an event lands in both flag words on the next edge
  a_r5_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bits != 32'h0 && !soft_rst_hit) |=>
      ((flag_a_q & $past(ev_bits)) == $past(ev_bits)) &&
      ((flag_b_q & $past(ev_bits)) == $past(ev_bits)));

  // R6: a full clear of flag word A with no event drops irq_a
  a_r6_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(8'h18) && bus_size == 2'd2 &&
     bus_wdata == 32'hFFFF_FFFF && ev_bits == 32'h0) |=> !irq_a);

  // R9: wakeup request is sticky
  a_r9_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !soft_rst_hit) |=> wake_req);

  // R9: wakeup request rises only for a gated, enabled event
  a_r9_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(wake_ok && ((ev_bits & wake_en_q) != 32'h0)));

  // R1: health word reads 1
  a_r1_health: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(8'h14) && bus_size == 2'd2) |->
      bus_rdata == 32'h1);
endmodule

bind gpio_evt_bank gpio_evt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
  .bus_addr (bus_addr), .bus_size (bus_size), .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata), .irq_a (irq_a), .wake_req (wake_req),
  .ev_bits (ev_bits), .dir_q (dir_q), .flag_a_q (flag_a_q), .flag_b_q (flag_b_q),
  .wake_ok (wake_ok), .wake_en_q (wake_en_q), .soft_rst_hit (soft_rst_hit)
);

// File: tb/test_gpio_evt_bank.sv
module test_gpio_evt_bank;
  localparam logic [7:0] REV = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_drive_en;
  logic        irq_a, irq_b, wake_req;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  gpio_evt_bank #(.REV_ID(REV)) i_gpio_evt_bank (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_size (bus_size), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .pin_in (pin_in), .pin_out (pin_out),
    .pin_drive_en (pin_drive_en), .irq_a (irq_a), .irq_b (irq_b), .wake_req (wake_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp,
                        input logic [1:0] sz = 2'd2);
    logic [31:0] d;
    rd(a, d, sz);
    check(tag, d, exp);
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 drive_en", pin_drive_en, 32'h0);
    check("R1 irq_a", {31'h0, irq_a}, 32'h0);
    check("R1 irq_b", {31'h0, irq_b}, 32'h0);
    check("R1 wake", {31'h0, wake_req}, 32'h0);
    rd_chk("R1 dir", 8'h34, 32'hFFFF_FFFF);
    rd_chk("R1 ctrl", 8'h30, 32'h2);
    rd_chk("R1 ident", 8'h00, {24'h0, REV});
    rd_chk("R1 health", 8'h14, 32'h1);
    rd_chk("R1 dout", 8'h3C, 32'h0);
    rd_chk("R1 flag_a", 8'h18, 32'h0);
    rd_chk("R12 unmapped", 8'h58, 32'h0);
  endtask

  task automatic t_direction;
    wr(8'h34, 32'hFFFF_00FF);
    wr(8'h3C, 32'h0000_A500);
    check("R2 drive_en", pin_drive_en, 32'h0000_FF00);
    check("R2 pin_out", pin_out, 32'h0000_A500);
    wr(8'h34, 32'hFFFF_FFFF);
    check("R2 drive_en off", pin_drive_en, 32'h0);
    wr(8'h3C, 32'h0);
  endtask

  task automatic t_edges;
    wr(8'h48, 32'h1);
    wr(8'h4C, 32'h2);
    pins(32'h3);
    rd_chk("R3 din", 8'h38, 32'h3);
    rd_chk("R3 rise flag_a", 8'h18, 32'h1);
    rd_chk("R3 rise flag_b", 8'h28, 32'h1);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R5 w1c flag_a", 8'h18, 32'h0);
    pins(32'h0);
    rd_chk("R3 fall flag_a", 8'h18, 32'h2);
    rd_chk("R3 fall flag_b", 8'h28, 32'h2);
    // R6: independent enables
    check("R6 irq_a masked", {31'h0, irq_a}, 32'h0);
    wr(8'h2C, 32'h2);
    check("R6 irq_b on", {31'h0, irq_b}, 32'h1);
    check("R6 irq_a still off", {31'h0, irq_a}, 32'h0);
    wr(8'h64, 32'h2);
    check("R6 irq_a on", {31'h0, irq_a}, 32'h1);
    wr(8'h18, 32'h2);
    check("R6 irq_a cleared", {31'h0, irq_a}, 32'h0);
    check("R6 irq_b kept", {31'h0, irq_b}, 32'h1);
    wr(8'h28, 32'hFFFF_FFFF);
    check("R6 irq_b cleared", {31'h0, irq_b}, 32'h0);
    // R3: output pins are ignored
    wr(8'h34, 32'hFFFF_FFFE);
    pins(32'h1);
    rd_chk("R3 output pin ignored", 8'h18, 32'h0);
    wr(8'h48, 32'h0);
    wr(8'h4C, 32'h0);
    wr(8'h34, 32'hFFFF_FFFF);
    pins(32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0);
    wr(8'h2C, 32'h0);
  endtask

  task automatic t_level;
    wr(8'h44, 32'h8);
    pins(32'h8);
    rd_chk("R4 high level", 8'h18, 32'h8);
    wr(8'h18, 32'h8);
    rd_chk("R4 re-set after clear", 8'h18, 32'h8);
    wr(8'h40, 32'h10);
    rd_chk("R4 low level on write", 8'h28, 32'h18);
    wr(8'h44, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R4 cleared after disable", 8'h18, 32'h0);
    pins(32'h0);
  endtask

  task automatic t_alias;
    wr(8'h64, 32'hF0F0_0000);
    rd_chk("R7 ena_a base", 8'h1C, 32'hF0F0_0000);
    rd_chk("R7 ena_a clr alias read", 8'h60, 32'hF0F0_0000);
    wr(8'h60, 32'h1000_0000);
    rd_chk("R7 ena_a cleared", 8'h64, 32'hE0F0_0000);
    wr(8'h74, 32'h0000_00C3);
    wr(8'h70, 32'h0000_0001);
    rd_chk("R7 ena_b", 8'h2C, 32'h0000_00C2);
    wr(8'h84, 32'h0000_0030);
    wr(8'h80, 32'h0000_0010);
    rd_chk("R7 wake_en", 8'h20, 32'h0000_0020);
    wr(8'h94, 32'h8000_0005);
    wr(8'h90, 32'h0000_0004);
    rd_chk("R7 dout", 8'h90, 32'h8000_0001);
    check("R7 pin_out", pin_out, 32'h8000_0001);
    wr(8'h1C, 32'h0);
    wr(8'h2C, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h3C, 32'h0);
  endtask

  task automatic t_subword;
    wr(8'h3C, 32'h1122_3344);
    wr(8'h3E, 32'h0000_00AA, 2'd0);
    rd_chk("R8 byte merge", 8'h3C, 32'h11AA_3344);
    wr(8'h3E, 32'h0000_BEEF, 2'd1);
    rd_chk("R8 half merge", 8'h3C, 32'hBEEF_3344);
    rd_chk("R8 byte read shift", 8'h3D, 32'h00BE_EF33, 2'd0);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h61, 32'h0000_000F, 2'd0);
    rd_chk("R8 alias zero lanes", 8'h1C, 32'hFFFF_F0FF);
    wr(8'h1C, 32'h0);
    wr(8'h3C, 32'h0);
  endtask

  task automatic t_wake;
    wr(8'h20, 32'h20);
    wr(8'h48, 32'h20);
    pins(32'h20);
    check("R9 gate closed", {31'h0, wake_req}, 32'h0);
    pins(32'h0);
    wr(8'h10, 32'h04);
    pins(32'h20);
    check("R9 idle zero", {31'h0, wake_req}, 32'h0);
    pins(32'h0);
    wr(8'h10, 32'h0C);
    pins(32'h20);
    check("R9 wake raised", {31'h0, wake_req}, 32'h1);
    pins(32'h0);
    wr(8'h10, 32'h00);
    wr(8'h18, 32'hFFFF_FFFF);
    check("R9 wake sticky", {31'h0, wake_req}, 32'h1);
    // R10: soft reset
    wr(8'h3C, 32'h55);
    wr(8'h10, 32'hFF);
    check("R10 soft reset wake", {31'h0, wake_req}, 32'h0);
    rd_chk("R10 cfg masked", 8'h10, 32'h1D);
    rd_chk("R10 dir restored", 8'h34, 32'hFFFF_FFFF);
    rd_chk("R10 rise restored", 8'h48, 32'h0);
    rd_chk("R10 flag_b restored", 8'h28, 32'h0);
    check("R10 dout restored", pin_out, 32'h0);
    wr(8'h10, 32'h18);
    rd_chk("R10 idle 3 stored", 8'h10, 32'h18);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_readonly;
    wr(8'h00, 32'h0000_FFFF);
    wr(8'h14, 32'h0);
    wr(8'h38, 32'hFFFF_FFFF);
    rd_chk("R11 ident ro", 8'h00, {24'h0, REV});
    rd_chk("R11 health ro", 8'h14, 32'h1);
    rd_chk("R11 din ro", 8'h38, 32'h0);
    wr(8'h50, 32'hDEAD_BEEF);
    rd_chk("R11 dbc_en", 8'h50, 32'hDEAD_BEEF);
    wr(8'h54, 32'h0000_01FF);
    rd_chk("R11 dbc_time 8 bits", 8'h54, 32'h0000_00FF);
    wr(8'h30, 32'h0000_00FF);
    rd_chk("R11 ctrl 3 bits", 8'h30, 32'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_edges();
    t_level();
    t_alias();
    t_subword();
    t_wake();
    t_readonly();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule